// File: doc/BRIEF.md
# Run-Length Sample Cluster Writer

This block sits between a logic-analyser front end and its capture memory. It takes one pin sample per sample-valid tick and stores samples only while pin levels are moving. Stored data is grouped into clusters of eight 16-bit memory words. The first word of a cluster holds the tick timestamp of its first sample. The other seven words hold the samples of that tick and the six ticks after it. When the levels stay flat and no cluster is open, nothing is written. The timestamp counter is free-running, so the gap between clusters is recovered from the timestamps.

Clusters fill a row from index 0 upwards. A row holds 64 clusters with the default parameters, and there are 32K rows, which wrap. So that a reader can always resolve timestamp rollover, a cluster is forced open whenever a tick lands on timestamp zero. A stop pulse freezes capture and closes any part-filled cluster. It also latches the position as a row and an event index, where the event index is the cluster index times seven plus the samples already stored in the open cluster. After a stop, the block ignores samples until reset.

The input side may present a sample-valid pulse at most every other clock. This gives the single write port the spare cycle it needs when a cluster opens, because an opening tick produces two words.

Top module: `tsrle_writer`

## Requirements
- R1: A memory word address is {row, cluster index, word index[2:0]}. Word index 0 carries the timestamp, zero-extended, and word indices 1 to 7 carry samples in tick order.
- R2: The timestamp counter starts at 0 after reset and advances by one per accepted tick, wrapping at 2^TS_W. A cluster's timestamp word equals the count at the tick of its first sample.
- R3: A tick that arrives with no cluster open, with a sample equal to the last stored sample and a count other than 0, writes nothing. With no tick and no pending word, the write strobe stays low.
- R4: A tick whose sample differs from the last stored sample opens a cluster. The timestamp word is written in the cycle after the tick and the first sample word in the cycle after that. The last stored sample is 0 after reset.
- R5: A tick with no cluster open and a count of 0 opens a cluster even when the sample is unchanged.
- R6: While a cluster is open, every tick stores its sample in the next word, one cycle after the tick, whether or not it changed. The seventh sample closes the cluster and moves to the next cluster index.
- R7: The cluster index wraps from its maximum to 0 and advances the row. The row wraps from its maximum to 0 and sets round_o, which then stays set until reset.
- R8: A stop pulse sets stop_done_o one cycle later. It latches stop_pos_o = {row, cluster index*7 + samples in the open cluster} and closes an open cluster by advancing the cluster index. Later ticks and stops change no output and write nothing.
- R9: A stop and a sample-valid in the same cycle: the stop takes effect and that sample is dropped.
- R10: Sample-valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | DATA_W | Pin sample |
| smp_valid_i | input | 1 | Sample tick |
| stop_i | input | 1 | Stop capture pulse |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ROW_W+CLU_W+3 | Memory word address |
| wr_data_o | output | DATA_W | Memory write word |
| stop_done_o | output | 1 | Capture stopped, sticky |
| stop_pos_o | output | ROW_W+EVT_W | Latched stop position {row, event} |
| round_o | output | 1 | Row counter has wrapped, sticky |

## Verification
A tick that continues an open cluster writes its word one clock after the edge that samples it. An opening tick writes the timestamp word one clock after that edge and the first sample word two clocks after. The stop status, the stop position and the round flag all change on the edge that takes the stop or the closing tick. The bench reference model books each expected write against the exact edge number on which it is due. At the falling edge after every rising edge, it compares the write strobe, address, data and status outputs against that booking. Every cycle with nothing booked must show the strobe low.

// File: rtl/tsrle_pkg.sv
package tsrle_pkg;
  localparam int unsigned SLOTS  = 7;  // sample words per cluster
  localparam int unsigned WORD_W = 3;  // word index width inside a cluster

  // event index inside a row: whole clusters before, plus filled slots
  function automatic int unsigned evt_of(input int unsigned clu, input int unsigned filled);
    return clu * SLOTS + filled;
  endfunction
endpackage

// File: rtl/tsrle_stamp.sv
module tsrle_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_o <= '0;
    else if (adv_i) ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/tsrle_pos.sv
module tsrle_pos #(
  parameter int ROW_W = 15,
  parameter int CLU_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic [CLU_W-1:0] clu_o,
  output logic             round_o
);
  logic clu_last, row_last;
  assign clu_last = (clu_o == {CLU_W{1'b1}});
  assign row_last = (row_o == {ROW_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o   <= '0;
      clu_o   <= '0;
      round_o <= 1'b0;
    end else if (adv_i) begin
      clu_o <= clu_o + 1'b1;
      if (clu_last) begin
        row_o <= row_o + 1'b1;
        if (row_last) round_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsrle_wport.sv
module tsrle_wport #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] stamp_addr_i,
  input  logic [DATA_W-1:0] stamp_data_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [DATA_W-1:0] pend_data_i,
  input  logic [ADDR_W-1:0] store_addr_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      pend_v_q <= open_i;
      if (open_i) begin
        pend_addr_q <= pend_addr_i;
        pend_data_q <= pend_data_i;
      end
      wr_en_o <= open_i | store_i | pend_v_q;
      if (pend_v_q) begin
        wr_addr_o <= pend_addr_q;
        wr_data_o <= pend_data_q;
      end else if (open_i) begin
        wr_addr_o <= stamp_addr_i;
        wr_data_o <= stamp_data_i;
      end else if (store_i) begin
        wr_addr_o <= store_addr_i;
        wr_data_o <= store_data_i;
      end
    end
  end
endmodule

// File: rtl/tsrle_writer.sv
module tsrle_writer
  import tsrle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int ROW_W  = 15,
  parameter int CLU_W  = 6,
  parameter int EVT_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         smp_i,
  input  logic                      smp_valid_i,
  input  logic                      stop_i,
  output logic                      wr_en_o,
  output logic [ROW_W+CLU_W+2:0]    wr_addr_o,
  output logic [DATA_W-1:0]         wr_data_o,
  output logic                      stop_done_o,
  output logic [ROW_W+EVT_W-1:0]    stop_pos_o,
  output logic                      round_o
);
  localparam int ADDR_W = ROW_W + CLU_W + WORD_W;
  localparam int POS_W  = ROW_W + EVT_W;

  logic              stopped_q;
  logic [DATA_W-1:0] last_q;
  logic [WORD_W-1:0] fill_q;
  logic [TS_W-1:0]   ts_q;
  logic [ROW_W-1:0]  row_q;
  logic [CLU_W-1:0]  clu_q;

  // named events, shared with the checker
  logic tick, stop_evt, is_open, ts_zero, differs;
  logic open_now, store_more, close_full, close_stop, clu_adv;
  logic [WORD_W-1:0] fill_nxt;
  logic [EVT_W-1:0]  evt_now;

  assign tick       = smp_valid_i & ~stop_i & ~stopped_q;  // stop wins
  assign stop_evt   = stop_i & ~stopped_q;
  assign is_open    = (fill_q != '0);
  assign ts_zero    = (ts_q == '0);
  assign differs    = (smp_i != last_q);
  assign open_now   = tick & ~is_open & (differs | ts_zero);
  assign store_more = tick & is_open;
  assign fill_nxt   = fill_q + 1'b1;
  assign close_full = store_more & (fill_nxt == WORD_W'(SLOTS));
  assign close_stop = stop_evt & is_open;
  assign clu_adv    = close_full | close_stop;
  assign evt_now    = EVT_W'(evt_of(32'(clu_q), 32'(fill_q)));

  tsrle_stamp #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (tick),
    .ts_o  (ts_q)
  );

  tsrle_pos #(.ROW_W(ROW_W), .CLU_W(CLU_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (clu_adv),
    .row_o   (row_q),
    .clu_o   (clu_q),
    .round_o (round_o)
  );

  tsrle_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
    .clk          (clk),
    .rst_n        (rst_n),
    .open_i       (open_now),
    .store_i      (store_more),
    .stamp_addr_i ({row_q, clu_q, WORD_W'(0)}),
    .stamp_data_i (DATA_W'(ts_q)),
    .pend_addr_i  ({row_q, clu_q, WORD_W'(1)}),
    .pend_data_i  (smp_i),
    .store_addr_i ({row_q, clu_q, fill_nxt}),
    .store_data_i (smp_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q  <= 1'b0;
      last_q     <= '0;
      fill_q     <= '0;
      stop_pos_o <= '0;
    end else begin
      if (stop_evt) begin
        stopped_q  <= 1'b1;
        stop_pos_o <= POS_W'({row_q, evt_now});
      end
      if (open_now | store_more) last_q <= smp_i;
      if (clu_adv)         fill_q <= '0;
      else if (open_now)   fill_q <= WORD_W'(1);
      else if (store_more) fill_q <= fill_nxt;
    end
  end

  assign stop_done_o = stopped_q;
endmodule

// File: rtl/tsrle_writer_chk.sv
module tsrle_writer_chk #(
  parameter int ADDR_W = 24,
  parameter int TS_W   = 16,
  parameter int POS_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              stop_done_o,
  input logic [POS_W-1:0]  stop_pos_o,
  input logic              round_o,
  input logic              tick,
  input logic              open_now,
  input logic [TS_W-1:0]   ts_q
);
  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ts_q == TS_W'($past(ts_q) + 1'b1));

  p_ts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts_q));

  p_write_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(tick) || $past(open_now, 2)));

  p_stamp_then_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o[2:0] == 3'd0) |=>
      (wr_en_o && wr_addr_o[2:0] == 3'd1 &&
       wr_addr_o[ADDR_W-1:3] == $past(wr_addr_o[ADDR_W-1:3])));

  p_round_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    round_o |=> round_o);

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done_o |=> (stop_done_o && $stable(stop_pos_o)));

  p_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> !smp_valid_i);
endmodule

bind tsrle_writer tsrle_writer_chk #(
  .ADDR_W (ROW_W + CLU_W + 3),
  .TS_W   (TS_W),
  .POS_W  (ROW_W + EVT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid_i (smp_valid_i),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .stop_done_o (stop_done_o),
  .stop_pos_o  (stop_pos_o),
  .round_o     (round_o),
  .tick        (tick),
  .open_now    (open_now),
  .ts_q        (ts_q)
);

// File: tb/tsrle_writer_bench.sv
module tsrle_writer_bench;
  localparam int DATA_W = 16;
  localparam int TS_W   = 6;
  localparam int ROW_W  = 2;
  localparam int CLU_W  = 2;
  localparam int EVT_W  = 9;
  localparam int ADDR_W = ROW_W + CLU_W + 3;
  localparam int POS_W  = ROW_W + EVT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] smp = '0;
  logic              smp_valid = 1'b0;
  logic              stop = 1'b0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              stop_done;
  logic [POS_W-1:0]  stop_pos;
  logic              round_f;

  always #5 clk = ~clk;

  tsrle_writer #(.DATA_W(DATA_W), .TS_W(TS_W), .ROW_W(ROW_W), .CLU_W(CLU_W), .EVT_W(EVT_W)) u_tsrle_writer (
    .clk (clk), .rst_n (rst_n), .smp_i (smp), .smp_valid_i (smp_valid), .stop_i (stop),
    .wr_en_o (wr_en), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
    .stop_done_o (stop_done), .stop_pos_o (stop_pos), .round_o (round_f)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected writes booked by the edge number on which they appear
  bit [ADDR_W-1:0] exp_a [int];
  bit [DATA_W-1:0] exp_d [int];
  string           exp_t [int];

  // reference model state
  int m_ts = 0, m_fill = 0, m_clu = 0, m_row = 0, m_last = 0;
  bit m_round = 0, m_stopped = 0;
  int m_pos = 0;

  // R1: word address is {row, cluster, word index}
  function automatic int mk_addr(int row, int clu, int w);
    return (row << (CLU_W + 3)) | (clu << 3) | w;
  endfunction

  task automatic book(int due, int a, int d, string tag);
    exp_a[due] = ADDR_W'(a);
    exp_d[due] = DATA_W'(d);
    exp_t[due] = tag;
  endtask

  task automatic close_cluster();
    m_fill = 0;
    m_clu++;
    if (m_clu == (1 << CLU_W)) begin
      m_clu = 0;
      m_row++;
      if (m_row == (1 << ROW_W)) begin m_row = 0; m_round = 1; end
    end
  endtask

  task automatic model(bit v, int s, bit st);
    if (m_stopped) return;
    if (st) begin  // R9: stop takes the cycle, a sample with it is dropped
      m_pos = (m_row << EVT_W) | (m_clu * 7 + m_fill);
      m_stopped = 1;
      if (m_fill != 0) close_cluster();
    end else if (v) begin
      if (m_fill == 0) begin
        if (s != m_last || m_ts == 0) begin
          book(cyc + 1, mk_addr(m_row, m_clu, 0), m_ts, (s != m_last) ? "R2" : "R5");
          book(cyc + 2, mk_addr(m_row, m_clu, 1), s, "R4");
          m_last = s;
          m_fill = 1;
        end
      end else begin
        book(cyc + 1, mk_addr(m_row, m_clu, m_fill + 1), s, "R6");
        m_last = s;
        m_fill++;
        if (m_fill == 7) close_cluster();
      end
      m_ts = (m_ts + 1) % (1 << TS_W);
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    if (exp_a.exists(cyc)) begin
      chk(wr_en == 1'b1, exp_t[cyc], "write strobe", int'(wr_en), 1);
      chk(wr_addr == exp_a[cyc], exp_t[cyc], "write address", int'(wr_addr), int'(exp_a[cyc]));
      chk(wr_data == exp_d[cyc], exp_t[cyc], "write data", int'(wr_data), int'(exp_d[cyc]));
      exp_a.delete(cyc); exp_d.delete(cyc); exp_t.delete(cyc);
    end else begin
      chk(wr_en == 1'b0, "R3", "idle write strobe", int'(wr_en), 0);
    end
    chk(round_f == m_round, "R7", "round flag", int'(round_f), int'(m_round));
    chk(stop_done == m_stopped, "R8", "stop done", int'(stop_done), int'(m_stopped));
    if (m_stopped) chk(stop_pos == POS_W'(m_pos), "R8", "stop position", int'(stop_pos), m_pos);
  endtask

  task automatic step(bit v, int s, bit st);
    @(negedge clk);
    compare();
    smp_valid = v;
    smp = DATA_W'(s);
    stop = st;
    model(v, s, st);
  endtask

  // R10: every tick is followed by at least one idle cycle
  task automatic tick(int s, int gap);
    step(1, s, 0);
    for (int g = 0; g < gap; g++) step(0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(0, 0, 0);  // reset state checked each cycle
    rst_n = 1'b1;
    // R5 forced cluster at count 0, then R3 silence on flat input, forced again on rollover
    for (int i = 0; i < 70; i++) tick(0, 1);
    // R2/R4/R6: slow changes
    for (int i = 0; i < 24; i++) tick(16'h1200 + i / 3, 1);
    // R7: enough clusters to wrap the rows, small alphabet gives repeats
    for (int i = 0; i < 320; i++) tick($urandom_range(0, 3), $urandom_range(1, 3));
    // R8/R9: stop inside a part-filled cluster, with a sample in the same cycle
    tick(16'hBEEF, 1);
    tick(16'hBEEF, 1);
    tick(16'h0BAD, 1);
    step(1, 16'h5555, 1);
    step(0, 0, 0);
    for (int i = 0; i < 10; i++) tick(16'h7000 + i, 1);  // ignored after stop
    step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    chk(exp_a.num() == 0, "R6", "unwritten bookings", exp_a.num(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule